// File: doc/BRIEF.md
# Interrupt Request Controller with Per-Line Trigger Modes

This block gathers interrupt request lines from a set of devices and presents at most one request to the processor at a time, as a valid flag and a vector number. The processor answers with a one-cycle acknowledge, which retires the request being presented. Every maskable line is set to level or edge detection by its own bit in a mode register. Each line can be held off by its own bit in a mask register. One further non-maskable line can never be held off.

All request inputs pass through a two-flop synchronizer. A level line is pending for as long as its synchronized input is high. An edge line latches each low-to-high transition, so a short pulse is kept while other requests are being served. The processor can only clear a latched edge by acknowledging it. Among unmasked pending lines the lowest index wins. The non-maskable line beats all of them.

Configuration is written through a simple write port: an enable, a select bit that picks the mask or the mode register, and a data word.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: After reset no request is presented, every maskable line is masked (mask bits all 1), and every line is in level mode (mode bits all 0).
- R2: A level-mode line (mode bit 0) is pending while its input is high, including after an acknowledge of its vector, and stops being pending once the input has been low for the two synchronizer cycles.
- R3: An edge-mode line (mode bit 1) becomes pending only on a low-to-high transition of its input. A line held high after its acknowledge is not presented again.
- R4: A rising edge on an edge-mode line is latched and kept while a different line is being presented or serviced, even if the input pulse has already ended.
- R5: A line whose mask bit is 1 is never presented. A latched edge on a masked line is kept and presented once the mask bit is cleared.
- R6: The non-maskable input is edge detected, ignores every mask bit, has the highest priority, and is presented as vector N_LINES. An acknowledge while it is presented clears it.
- R7: Among unmasked pending maskable lines, the one with the lowest index is presented, and its index is the vector.
- R8: A configuration write (select 0 = mask register, select 1 = mode register) takes effect at the clock edge that samples it, so outputs reflect the new value in the following cycle.
- R9: An acknowledge clears only the latched edge of the line being presented. Latched edges on other lines are kept. An acknowledge with no request presented has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N_LINES | Maskable request inputs from the devices |
| nmi_line | input | 1 | Non-maskable request input |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | Register select: 0 mask, 1 mode |
| cfg_wr_data | input | N_LINES | Value written to the selected register |
| irq_valid | output | 1 | A request is being presented |
| irq_vector | output | VEC_W | Vector of the presented request (N_LINES for the non-maskable one) |
| irq_ack | input | 1 | Processor acknowledge of the presented request |

## Verification
A latched edge bit that is stuck, or lost early, shows at the ports in one of two ways. Either a vector is presented again after its acknowledge, or a pulsed line is never presented once the higher-priority lines have been released. Both are visible within a few cycles of the acknowledge or the release. A wrong mask or mode bit shows one cycle after the configuration write, as a vector that should or should not appear. A broken synchronizer or edge detector shows as a request that comes too late, or never comes, after the input changes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   typedef enum logic {
      CFG_MASK = 1'b0,
      CFG_MODE = 1'b1
   } cfg_sel_e;

   function automatic int vec_width(input int lines);
      return $clog2(lines + 1);
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/irq_line_unit.sv
module irq_line_unit #(
   parameter int N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] sync_in,
   input  logic [N_LINES-1:0] edge_mode,
   input  logic [N_LINES-1:0] clr,
   output logic [N_LINES-1:0] pending
);
   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic prev_q;
      logic latch_q;
      logic rise;

      assign rise = sync_in[i] & ~prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
         end else begin
            prev_q  <= sync_in[i];
            latch_q <= edge_mode[i] ? (rise | (latch_q & ~clr[i])) : 1'b0;
         end
      end

      assign pending[i] = edge_mode[i] ? latch_q : sync_in[i];

      // R4: a detected edge is always latched
      p_edge_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_mode[i] && rise) |=> latch_q);
      // R9: acknowledge retires the latch when no new edge coincides
      p_edge_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !rise) |=> !latch_q);
   end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int N_LINES = 8,
   parameter int VEC_W   = 4
) (
   input  logic [N_LINES-1:0] active,
   input  logic               nmi_pend,
   output logic               valid,
   output logic [VEC_W-1:0]   vector,
   output logic [N_LINES-1:0] grant,
   output logic               nmi_grant
);
   logic [VEC_W-1:0] low_idx;
   logic             any;

   always_comb begin
      low_idx = '0;
      any     = 1'b0;
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (active[i]) begin
            low_idx = VEC_W'(i);
            any     = 1'b1;
         end
      end
   end

   always_comb begin
      grant     = '0;
      nmi_grant = nmi_pend;
      valid     = nmi_pend | any;
      vector    = '0;
      if (nmi_pend) begin
         vector = VEC_W'(N_LINES);
      end else if (any) begin
         vector = low_idx;
         grant  = active & ~(active - N_LINES'(1));
      end
   end
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int N_LINES = 8,
   parameter int VEC_W   = vec_width(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_lines,
   input  logic               nmi_line,
   input  logic               cfg_wr_en,
   input  logic               cfg_wr_sel,
   input  logic [N_LINES-1:0] cfg_wr_data,
   output logic               irq_valid,
   output logic [VEC_W-1:0]   irq_vector,
   input  logic               irq_ack
);
   localparam int SYNC_W = N_LINES + 1;

   if (N_LINES < 1) begin : g_bad_lines
      $error("N_LINES must be at least 1");
   end
   if (VEC_W < vec_width(N_LINES)) begin : g_bad_vec
      $error("VEC_W too narrow for the non-maskable vector");
   end

   logic [SYNC_W-1:0]  sync_q;
   logic [N_LINES-1:0] line_sync;
   logic               nmi_sync;
   logic [N_LINES-1:0] mask_q;
   logic [N_LINES-1:0] mode_q;
   logic [N_LINES-1:0] pending;
   logic [N_LINES-1:0] active;
   logic [N_LINES-1:0] grant;
   logic [N_LINES-1:0] line_clr;
   logic               nmi_grant;
   logic               nmi_prev_q;
   logic               nmi_pend_q;
   logic               nmi_rise;
   logic               ack_ok;

   irq_sync #(.W(SYNC_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({nmi_line, irq_lines}),
      .q     (sync_q)
   );
   assign line_sync = sync_q[N_LINES-1:0];
   assign nmi_sync  = sync_q[N_LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         mode_q <= '0;
      end else if (cfg_wr_en) begin
         if (cfg_sel_e'(cfg_wr_sel) == CFG_MASK) mask_q <= cfg_wr_data;
         else                                    mode_q <= cfg_wr_data;
      end
   end

   assign ack_ok   = irq_ack & irq_valid;
   assign line_clr = ack_ok ? grant : '0;

   irq_line_unit #(.N_LINES(N_LINES)) u_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (line_sync),
      .edge_mode (mode_q),
      .clr       (line_clr),
      .pending   (pending)
   );

   assign nmi_rise = nmi_sync & ~nmi_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b0;
         nmi_pend_q <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_sync;
         nmi_pend_q <= nmi_rise | (nmi_pend_q & ~(ack_ok & nmi_grant));
      end
   end

   assign active = pending & ~mask_q;

   irq_prio_arb #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_arb (
      .active    (active),
      .nmi_pend  (nmi_pend_q),
      .valid     (irq_valid),
      .vector    (irq_vector),
      .grant     (grant),
      .nmi_grant (nmi_grant)
   );

   // R6: the non-maskable request always wins
   p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend_q |-> (irq_valid && irq_vector == VEC_W'(N_LINES)));
   // R5: a masked line is never granted
   p_mask_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !nmi_grant) |-> ((grant & mask_q) == '0));
   // R7: the granted line has no active line below it
   p_prio_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !nmi_grant) |->
         ($countones(grant) == 1 && (active & (grant - N_LINES'(1))) == '0));
   // R8: a mask write is visible in the next cycle
   p_wr_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_sel == 1'b0) |=> (mask_q == $past(cfg_wr_data)));
endmodule

// File: tb/tb_irq_trigger_ctrl.sv
module tb_irq_trigger_ctrl;
   localparam int N = 8;
   localparam int VW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_lines = '0;
   logic          nmi_line = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic          cfg_wr_sel = 1'b0;
   logic [N-1:0]  cfg_wr_data = '0;
   logic          irq_valid;
   logic [VW-1:0] irq_vector;
   logic          irq_ack = 1'b0;

   int total = 0;
   int bad = 0;
   int seed_init;

   always #5 clk = ~clk;

   irq_trigger_ctrl #(.N_LINES(N)) dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_line(nmi_line),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
      .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ack(irq_ack)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_req(input string req, input bit v, input int vec);
      check(irq_valid == v, req, int'(irq_valid), int'(v));
      if (v) check(int'(irq_vector) == vec, req, int'(irq_vector), vec);
   endtask

   task automatic cfg(input bit sel, input logic [N-1:0] data);
      cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
      tick(1);
      cfg_wr_en = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      tick(1);
      irq_ack = 1'b0;
   endtask

   task automatic pulse(input int idx);
      irq_lines[idx] = 1'b1;
      tick(3);
      irq_lines[idx] = 1'b0;
   endtask

   function automatic int low_vec(input logic [N-1:0] a);
      for (int i = 0; i < N; i++) if (a[i]) return i;
      return 0;
   endfunction

   initial begin
      seed_init = $urandom(32'd2024);
      tick(3);
      rst_n = 1'b1;
      tick(1);
      expect_req("R1 idle after reset", 1'b0, 0);
      irq_lines[0] = 1'b1;
      tick(4);
      expect_req("R1 masked by default", 1'b0, 0);
      cfg(1'b0, '0);
      expect_req("R8 unmask next cycle", 1'b1, 0);

      ack(); tick(1);
      expect_req("R2 level survives ack", 1'b1, 0);
      irq_lines[0] = 1'b0;
      tick(3);
      expect_req("R2 level withdrawn", 1'b0, 0);

      cfg(1'b1, 8'h08);
      irq_lines[3] = 1'b1;
      tick(4);
      expect_req("R3 edge seen", 1'b1, 3);
      ack(); tick(3);
      expect_req("R3 held high no re-request", 1'b0, 0);
      irq_lines[3] = 1'b0;
      tick(3);

      irq_lines[2] = 1'b1; irq_lines[5] = 1'b1;
      tick(4);
      expect_req("R7 lowest index", 1'b1, 2);
      irq_lines[2] = 1'b0;
      tick(3);
      expect_req("R7 next index", 1'b1, 5);
      irq_lines[5] = 1'b0;
      tick(3);

      irq_lines[0] = 1'b1;
      tick(4);
      pulse(3); tick(2);
      expect_req("R4 level line 0 first", 1'b1, 0);
      irq_lines[0] = 1'b0;
      tick(3);
      expect_req("R4 pulse kept", 1'b1, 3);
      ack();
      expect_req("R9 ack clears edge", 1'b0, 0);
      ack();
      expect_req("R9 idle ack no effect", 1'b0, 0);

      cfg(1'b1, 8'h48);
      pulse(3); pulse(6); tick(2);
      expect_req("R9 first edge", 1'b1, 3);
      ack();
      expect_req("R9 other edge kept", 1'b1, 6);
      ack();
      expect_req("R9 all retired", 1'b0, 0);

      cfg(1'b0, 8'h08);
      pulse(3); tick(2);
      expect_req("R5 masked edge hidden", 1'b0, 0);
      cfg(1'b0, 8'h00);
      expect_req("R5 kept edge after unmask", 1'b1, 3);
      ack();

      cfg(1'b0, 8'hFF);
      nmi_line = 1'b1; tick(3); nmi_line = 1'b0; tick(2);
      expect_req("R6 nmi ignores mask", 1'b1, N);
      ack();
      expect_req("R6 nmi cleared", 1'b0, 0);
      cfg(1'b0, 8'h00);
      irq_lines[1] = 1'b1;
      nmi_line = 1'b1; tick(3); nmi_line = 1'b0; tick(2);
      expect_req("R6 nmi beats line 1", 1'b1, N);
      ack();
      expect_req("R6 line 1 after nmi", 1'b1, 1);
      irq_lines[1] = 1'b0;
      tick(3);

      cfg(1'b1, 8'h00);
      for (int k = 0; k < 24; k++) begin
         logic [N-1:0] m;
         logic [N-1:0] r;
         logic [N-1:0] a;
         m = N'($urandom);
         r = N'($urandom);
         irq_lines = r;
         cfg(1'b0, m);
         tick(3);
         a = r & ~m;
         expect_req("R7 random level pattern", |a, low_vec(a));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule